// File: doc/BRIEF.md
# Pseudo-Static RAM Core with Hidden Refresh

This block is the device-side logic of a pseudo-static RAM made of 16-bit words. The asynchronous control pins are two chip selects (one active low, one active high), output enable, write enable, and an enable for each byte lane. An internal clock samples these pins, together with the address and write data, through a synchronizer chain. The block decodes the pins into reads and byte-masked writes on a behavioural storage array. For each byte lane it gives a drive enable that stands in for the tri-state output buffer. The depth is a parameter and is kept small by default so the behavioural array stays compact.

The storage is treated like dynamic cells. A refresh scheduler asks for a refresh once a fixed interval has passed since the last one. It runs that refresh only after the device has been deselected for more than a set number of clock cycles. A started refresh always runs to completion. An access that arrives meanwhile is held off and flagged as busy. A select window longer than the refresh deadline sets a sticky data-loss flag. After reset, an initialisation period blocks every access.

All time constants are clock-cycle counts derived from a clock-frequency parameter, so a short simulation can use scaled values. A second build parameter removes the active-high select for the package variant that lacks that pin. In that build the select is treated as always asserted.

Top module: `psram_core`

## Requirements
- R1: The device is deselected whenever the sampled `cs1_n` is 1 or the sampled `cs2` is 0. While deselected, `dq_oe` is 2'b00, whatever the other pins hold.
- R2: A word is written while the device is selected, ready, not refreshing and `we_n` is 0. `lb_n`=0 enables bits 7..0 and `ub_n`=0 enables bits 15..8. A lane whose enable is 1 keeps its old byte, and with both enables at 1 nothing is written.
- R3: A read drives lanes while the device is selected, ready, not refreshing, `we_n`=1 and `oe_n`=0. `dq_oe` bit 0 follows `lb_n`=0 and bit 1 follows `ub_n`=0. `dq_out` carries the stored byte on each driven lane and zero on each lane that is not driven.
- R4: With `we_n`=1 and `oe_n`=1, no lane is driven. During a write no lane is driven, even with `oe_n`=0.
- R5: `ref_req` is 1 once REF_INT_CYC ready cycles (half the deadline) have passed since the last refresh. A refresh starts only when `ref_req` is 1 and the sampled select has been inactive for more than GAP_CYC consecutive cycles. It lasts REF_LEN_CYC cycles and ends with a one-cycle `ref_done` pulse, in the same cycle that `ref_req` falls.
- R6: `data_loss` becomes 1 once the sampled select has been active for more than DEADLINE_CYC consecutive ready cycles. It then stays 1 until reset.
- R7: After reset, `ready` stays 0 for INIT_CYC = CLK_MHZ*INIT_US cycles and then becomes 1. While `ready` is 0, no write changes storage and no lane is driven.
- R8: With HAS_CS2=0, the `cs2` pin is ignored and treated as asserted.
- R9: If the device is selected while a refresh runs, `busy` is 1 and the access is held off. No lane is driven and no write lands until the refresh ends, and then the access proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select (ignored when HAS_CS2=0) |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| ub_n | input | 1 | Active-low enable for bits 15..8 |
| lb_n | input | 1 | Active-low enable for bits 7..0 |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, zero on lanes not driven |
| dq_oe | output | 2 | Lane drive enables (bit 0 low byte, bit 1 high byte) |
| ready | output | 1 | Initialisation period complete |
| ref_req | output | 1 | Refresh is due |
| ref_done | output | 1 | One-cycle pulse when a refresh finishes |
| busy | output | 1 | Selected while a refresh is running |
| data_loss | output | 1 | Sticky flag: select window exceeded the deadline |

## Verification
The bench builds the core with ADDR_W=6, CLK_MHZ=2, GAP_CYC=2 and REF_LEN_CYC=4. This gives a 100-cycle initialisation, a 30-cycle deadline and a refresh due every 15 cycles. With these values the exact cycle of the ready edge, the cycle a refresh starts after deselection, and the cycle of the refresh-done pulse can all be reached and checked. Select windows above and below the deadline can also be checked in a short run. A second instance built with HAS_CS2=0 shares the stimulus, but its `cs2` is tied low, so the ignored pin can be compared against the main instance. A mid-run reset shows that storage survives while the initialisation period blocks writes again.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int unsigned DQ_W   = 16;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = DQ_W / LANES;

  // Sampled control pins; bit order fixes the synchronizer reset value.
  typedef struct packed {
    logic cs1_n;
    logic cs2;
    logic oe_n;
    logic we_n;
    logic ub_n;
    logic lb_n;
  } psram_pins_t;

  localparam psram_pins_t PINS_IDLE = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1,
                                        we_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1};

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_READ,
    ACC_WRITE,
    ACC_HELD
  } psram_acc_e;

  function automatic logic [LANES-1:0] lane_enables(input psram_pins_t p);
    return ~{p.ub_n, p.lb_n};
  endfunction

endpackage

// File: rtl/psram_pin_sync.sv
module psram_pin_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= d;
      end
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      logic [STAGES-1:0][W-1:0] stg_d;
      always_comb begin
        stg_d = {stg_q[STAGES-2:0], d};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched #(
  parameter int unsigned INIT_CYC     = 5000,
  parameter int unsigned DEADLINE_CYC = 1500,
  parameter int unsigned REF_INT_CYC  = 750,
  parameter int unsigned GAP_CYC      = 1,
  parameter int unsigned REF_LEN_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic ready,
  output logic ref_req,
  output logic ref_active,
  output logic ref_done,
  output logic data_loss
);

  localparam int unsigned IW = $clog2(INIT_CYC + 1);
  localparam int unsigned DW = $clog2(DEADLINE_CYC + 2);
  localparam int unsigned AW = $clog2(REF_INT_CYC + 1);
  localparam int unsigned GW = $clog2(GAP_CYC + 2);
  localparam int unsigned LW = $clog2(REF_LEN_CYC + 1);

  logic [IW-1:0] init_q,  init_d;
  logic          rdy_q,   rdy_d;
  logic [GW-1:0] desel_q, desel_d;
  logic [DW-1:0] run_q,   run_d;
  logic [AW-1:0] age_q,   age_d;
  logic          act_q,   act_d;
  logic [LW-1:0] len_q,   len_d;
  logic          done_q,  done_d;
  logic          loss_q,  loss_d;
  logic          req_c;
  logic          start_c;

  // Initialisation window
  always_comb begin
    init_d = init_q;
    rdy_d  = rdy_q;
    if (!rdy_q) begin
      if (init_q == IW'(INIT_CYC - 1)) rdy_d  = 1'b1;
      else                             init_d = init_q + 1'b1;
    end
  end

  // Deselect run length, saturating just above the gap
  always_comb begin
    desel_d = desel_q;
    if (sel)                            desel_d = '0;
    else if (desel_q != GW'(GAP_CYC + 1)) desel_d = desel_q + 1'b1;
  end

  // Refresh request and start
  always_comb begin
    req_c   = rdy_q && (age_q == AW'(REF_INT_CYC));
    start_c = req_c && !act_q && !sel && (desel_q > GW'(GAP_CYC));
  end

  // Refresh execution, always runs to completion once started
  always_comb begin
    act_d  = act_q;
    len_d  = len_q;
    done_d = 1'b0;
    if (act_q) begin
      if (len_q == LW'(REF_LEN_CYC - 1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        len_d = len_q + 1'b1;
      end
    end else if (start_c) begin
      act_d = 1'b1;
      len_d = '0;
    end
  end

  // Age since last refresh
  always_comb begin
    age_d = age_q;
    if (done_d)                                    age_d = '0;
    else if (rdy_q && age_q != AW'(REF_INT_CYC)) age_d = age_q + 1'b1;
  end

  // Select window watchdog
  always_comb begin
    run_d = run_q;
    if (!sel || !rdy_q)                   run_d = '0;
    else if (run_q != DW'(DEADLINE_CYC)) run_d = run_q + 1'b1;
    loss_d = loss_q | (rdy_q && sel && (run_q == DW'(DEADLINE_CYC)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= '0;
      rdy_q   <= 1'b0;
      desel_q <= '0;
      run_q   <= '0;
      age_q   <= '0;
      act_q   <= 1'b0;
      len_q   <= '0;
      done_q  <= 1'b0;
      loss_q  <= 1'b0;
    end else begin
      init_q  <= init_d;
      rdy_q   <= rdy_d;
      desel_q <= desel_d;
      run_q   <= run_d;
      age_q   <= age_d;
      act_q   <= act_d;
      len_q   <= len_d;
      done_q  <= done_d;
      loss_q  <= loss_d;
    end
  end

  assign ready      = rdy_q;
  assign ref_req    = req_c;
  assign ref_active = act_q;
  assign ref_done   = done_q;
  assign data_loss  = loss_q;

endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DQ_W   = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   wdata,
  output logic [DQ_W-1:0]   rdata
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LANE_W = DQ_W / LANES;

  logic [DQ_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/psram_core.sv
module psram_core
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned INIT_US     = 50,
  parameter int unsigned DEADLINE_US = 15,
  parameter int unsigned GAP_CYC     = 1,
  parameter int unsigned REF_LEN_CYC = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_CS2     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe,
  output logic              ready,
  output logic              ref_req,
  output logic              ref_done,
  output logic              busy,
  output logic              data_loss
);

  localparam int unsigned INIT_CYC     = CLK_MHZ * INIT_US;
  localparam int unsigned DEADLINE_CYC = CLK_MHZ * DEADLINE_US;
  localparam int unsigned REF_INT_CYC  = DEADLINE_CYC / 2;
  localparam int unsigned BUS_W        = ADDR_W + DQ_W;

  psram_pins_t       pins_s;
  logic [5:0]        pins_raw_q;
  logic [BUS_W-1:0]  bus_q;
  logic [ADDR_W-1:0] addr_s;
  logic [DQ_W-1:0]   din_s;
  logic              cs2_eff;
  logic              sel_s;
  logic [LANES-1:0]  lanes_s;
  psram_acc_e        acc;
  logic              wr_en;
  logic              ref_active;
  logic [DQ_W-1:0]   rdata;
  logic [DQ_W-1:0]   lane_mask;

  psram_pin_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_ctrl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs1_n, cs2, oe_n, we_n, ub_n, lb_n}),
    .q    (pins_raw_q)
  );

  psram_pin_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({addr, dq_in}),
    .q    (bus_q)
  );

  assign pins_s = psram_pins_t'(pins_raw_q);
  assign addr_s = bus_q[BUS_W-1 -: ADDR_W];
  assign din_s  = bus_q[DQ_W-1:0];

  generate
    if (HAS_CS2) begin : g_cs2_pin
      assign cs2_eff = pins_s.cs2;
    end else begin : g_cs2_tied
      assign cs2_eff = 1'b1;
    end
  endgenerate

  assign sel_s   = !pins_s.cs1_n && cs2_eff;
  assign lanes_s = lane_enables(pins_s);

  psram_refresh_sched #(
    .INIT_CYC    (INIT_CYC),
    .DEADLINE_CYC(DEADLINE_CYC),
    .REF_INT_CYC (REF_INT_CYC),
    .GAP_CYC     (GAP_CYC),
    .REF_LEN_CYC (REF_LEN_CYC)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel_s),
    .ready     (ready),
    .ref_req   (ref_req),
    .ref_active(ref_active),
    .ref_done  (ref_done),
    .data_loss (data_loss)
  );

  // Access decode on sampled pins
  always_comb begin
    acc = ACC_NONE;
    if (sel_s && (lanes_s != '0)) begin
      if (!ready || ref_active) acc = ACC_HELD;
      else if (!pins_s.we_n)    acc = ACC_WRITE;
      else if (!pins_s.oe_n)    acc = ACC_READ;
    end
  end

  assign wr_en = (acc == ACC_WRITE);
  assign dq_oe = (acc == ACC_READ) ? lanes_s : '0;
  assign busy  = sel_s && ref_active;

  psram_array #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_lanes(lanes_s),
    .addr    (addr_s),
    .wdata   (din_s),
    .rdata   (rdata)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{dq_oe[l]}};
    end
  endgenerate

  assign dq_out = rdata & lane_mask;

endmodule

// File: rtl/psram_core_chk.sv
module psram_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_s,
  input logic [1:0] lanes_s,
  input logic       wr_en,
  input logic [1:0] dq_oe,
  input logic       ref_active,
  input logic       ref_done,
  input logic       ready,
  input logic       data_loss
);

  p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |-> (dq_oe == 2'b00));

  p_lane_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((dq_oe & ~lanes_s) == 2'b00));

  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (dq_oe == 2'b00));

  p_ref_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_active) |-> $past(!sel_s));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);

  p_loss_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_loss |=> data_loss);

  p_init_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!wr_en && dq_oe == 2'b00));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_active |-> (!wr_en && dq_oe == 2'b00));

endmodule

bind psram_core psram_core_chk u_psram_core_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_s     (sel_s),
  .lanes_s   (lanes_s),
  .wr_en     (wr_en),
  .dq_oe     (dq_oe),
  .ref_active(ref_active),
  .ref_done  (ref_done),
  .ready     (ready),
  .data_loss (data_loss)
);

// File: tb/psram_core_bench.sv
module psram_core_bench;

  localparam int unsigned AW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cs1_n = 1'b1, cs2 = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '0;

  logic [15:0] dq_out, n_dq_out;
  logic [1:0]  dq_oe, n_dq_oe;
  logic        ready, ref_req, ref_done, busy, data_loss;
  logic        n_ready, n_ref_req, n_ref_done, n_busy, n_data_loss;

  psram_core #(.ADDR_W(AW), .CLK_MHZ(2), .INIT_US(50), .DEADLINE_US(15), .GAP_CYC(2),
               .REF_LEN_CYC(4), .SYNC_STAGES(2), .HAS_CS2(1'b1)) u_psram_core (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe),
    .ready(ready), .ref_req(ref_req), .ref_done(ref_done), .busy(busy), .data_loss(data_loss));

  psram_core #(.ADDR_W(AW), .CLK_MHZ(2), .INIT_US(50), .DEADLINE_US(15), .GAP_CYC(2),
               .REF_LEN_CYC(4), .SYNC_STAGES(2), .HAS_CS2(1'b0)) u_psram_core_nocs2 (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(1'b0), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .dq_in(din), .dq_out(n_dq_out), .dq_oe(n_dq_oe),
    .ready(n_ready), .ref_req(n_ref_req), .ref_done(n_ref_done), .busy(n_busy),
    .data_loss(n_data_loss));

  typedef struct {
    string       req;
    int          kind;
    logic [17:0] exp;
  } item_t;

  item_t sb_q[$];
  event  smp_ev;
  int    total = 0;
  int    bad   = 0;

  // kind 0: {dq_oe,dq_out}; 1: {ready,busy,data_loss,ref_req,ref_done};
  // 2: second instance {dq_oe,dq_out}; 3: data_loss
  task automatic push_exp(string req, int kind, logic [17:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
    -> smp_ev;
  endtask

  function automatic logic [17:0] rd(logic [1:0] oe, logic [15:0] d);
    return {oe, d};
  endfunction

  function automatic logic [17:0] st(logic r, logic b, logic l, logic q, logic d);
    return {13'b0, r, b, l, q, d};
  endfunction

  initial begin
    forever begin
      @(smp_ev);
      while (sb_q.size() > 0) begin
        item_t       it;
        logic [17:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = {dq_oe, dq_out};
          1:       act = {13'b0, ready, busy, data_loss, ref_req, ref_done};
          2:       act = {n_dq_oe, n_dq_out};
          default: act = {17'b0, data_loss};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic c1, logic c2, logic oe, logic we, logic ub, logic lb,
                       logic [AW-1:0] a, logic [15:0] d);
    cs1_n = c1; cs2 = c2; oe_n = oe; we_n = we; ub_n = ub; lb_n = lb; addr = a; din = d;
  endtask

  task automatic idle(int n);
    drive(1, 1, 1, 1, 1, 1, '0, '0);
    cyc(n);
  endtask

  // write with oe_n low: no lane may be driven (R4)
  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic ub, logic lb);
    drive(0, 1, 0, 0, ub, lb, a, d);
    cyc(10);
    push_exp("R4 write drives nothing", 0, rd(2'b00, 16'h0000));
    idle(6);
  endtask

  task automatic do_read(string req, logic [AW-1:0] a, logic ub, logic lb,
                         logic [1:0] eoe, logic [15:0] ed);
    drive(0, 1, 0, 1, ub, lb, a, '0);
    cyc(10);
    push_exp(req, 0, rd(eoe, ed));
    idle(6);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    push_exp("R7 reset state", 1, st(0, 0, 0, 0, 0));
    // read attempt during initialisation
    drive(0, 1, 0, 1, 0, 0, 6'd3, '0);
    cyc(10);
    push_exp("R7 no drive during init", 0, rd(2'b00, 16'h0000));
    idle(89);
    push_exp("R7 not ready at cycle 99", 1, st(0, 0, 0, 0, 0));
    cyc(1);
    push_exp("R7 ready at cycle 100", 3, 18'h0);
    if (ready !== 1'b1) begin
      total++; bad++;
      $display("FAIL R7 ready act=%b exp=1", ready);
    end else total++;

    do_write(6'd3, 16'h1234, 0, 0);
    do_read("R3 full read", 6'd3, 0, 0, 2'b11, 16'h1234);
    do_write(6'd3, 16'hFFAB, 1, 0);
    do_write(6'd3, 16'hCDFF, 0, 1);
    do_read("R2 byte-masked writes", 6'd3, 0, 0, 2'b11, 16'hCDAB);
    do_read("R3 low lane only", 6'd3, 1, 0, 2'b01, 16'h00AB);
    do_read("R3 high lane only", 6'd3, 0, 1, 2'b10, 16'hCD00);
    do_write(6'd3, 16'h0000, 1, 1);
    do_read("R2 no-lane write ignored", 6'd3, 0, 0, 2'b11, 16'hCDAB);
    do_write(6'd9, 16'h5A5A, 0, 0);
    do_read("R3 second address", 6'd9, 0, 0, 2'b11, 16'h5A5A);

    drive(0, 1, 1, 1, 0, 0, 6'd3, '0);
    cyc(10);
    push_exp("R4 oe_n high no drive", 0, rd(2'b00, 16'h0000));
    idle(6);

    drive(1, 1, 0, 1, 0, 0, 6'd3, '0);
    cyc(10);
    push_exp("R1 cs1_n high deselects", 0, rd(2'b00, 16'h0000));
    idle(6);
    drive(0, 0, 0, 1, 0, 0, 6'd3, '0);
    cyc(10);
    push_exp("R1 cs2 low deselects", 0, rd(2'b00, 16'h0000));
    push_exp("R8 cs2 ignored without pin", 2, rd(2'b11, 16'hCDAB));
    idle(6);

    // R5: refresh waits for deselect
    @(posedge ref_done);
    @(negedge clk);
    drive(0, 1, 0, 1, 0, 0, 6'd3, '0);
    cyc(25);
    push_exp("R5 request held while selected", 1, st(1, 0, 0, 1, 0));
    drive(1, 1, 1, 1, 1, 1, '0, '0);
    cyc(9);
    push_exp("R5 refresh not done before gap+length", 1, st(1, 0, 0, 1, 0));
    cyc(1);
    push_exp("R5 done pulse and request drop", 1, st(1, 0, 0, 0, 1));

    // R9: select arrives while refresh runs
    @(posedge ref_req);
    @(negedge clk);
    drive(0, 1, 0, 1, 0, 0, 6'd3, '0);
    cyc(3);
    push_exp("R9 busy during refresh", 1, st(1, 1, 0, 1, 0));
    push_exp("R9 read held off", 0, rd(2'b00, 16'h0000));
    cyc(2);
    push_exp("R9 busy clears at done", 1, st(1, 0, 0, 0, 1));
    cyc(1);
    push_exp("R9 read proceeds", 0, rd(2'b11, 16'hCDAB));
    idle(6);

    // R6: overlong select window
    drive(0, 1, 0, 1, 0, 0, 6'd3, '0);
    cyc(40);
    push_exp("R6 loss flagged", 3, 18'h1);
    idle(5);
    push_exp("R6 loss sticky", 3, 18'h1);

    // second reset: storage kept, init blocks writes
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    push_exp("R6 loss cleared by reset", 3, 18'h0);
    push_exp("R7 reset state again", 1, st(0, 0, 0, 0, 0));
    drive(0, 1, 1, 0, 0, 0, 6'd3, 16'h0000);
    cyc(10);
    idle(100);
    do_read("R7 write during init ignored", 6'd3, 0, 0, 2'b11, 16'hCDAB);

    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule